// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block turns a single burst request into the list of byte addresses that the burst touches, one address per beat. A request carries a start address, a length field (beats minus one), a size code (log2 of bytes per beat) and a two-bit kind code. Once a request is taken, the block presents the beat addresses in order on a VALID/READY output. It marks the final beat with a last flag. It takes no new request until that final beat has been handed over.

Three kinds of burst are produced. A fixed burst repeats the start address. An incrementing burst steps upward by the beat size. A wrapping burst steps upward inside a window aligned to the burst's total byte count and folds back to the bottom of that window. A request that cannot form a legal wrapping burst, or that carries the reserved kind code, is refused. The block pulses an error flag for it and emits no address.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, beat_valid is 0, beat_last is 0, req_err is 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. For a legal request, beat_valid is 1 from the next cycle, and the first beat address equals req_addr.
- R3: A legal request produces exactly req_len+1 beats. beat_last is 1 on the final beat and 0 on every earlier beat.
- R4: Kind code 2'b00 (fixed): every beat address equals the start address.
- R5: Kind code 2'b01 (incrementing): each later beat address is the previous address rounded down to a multiple of 2^req_size, plus 2^req_size, modulo 2^ADDR_W.
- R6: Kind code 2'b10 (wrapping): with T = (req_len+1)·2^req_size and L = start address rounded down to a multiple of T, each step adds 2^req_size. When the sum equals L+T, the next address is L instead.
- R7: A wrapping request is legal only when req_len is 1, 3, 7 or 15 and req_addr is a multiple of 2^req_size. Otherwise req_err is 1 for exactly the cycle after the request is taken, no beat is emitted, and req_ready stays 1.
- R8: Kind code 2'b11 is refused in the same way as an illegal wrapping request.
- R9: While beat_valid is 1 and beat_ready is 0, beat_valid stays 1 and beat_addr and beat_last keep their values.
- R10: req_ready is 0 while a burst is in progress. It returns to 1 in the cycle after the handshake of the final beat, and beat_valid is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A burst request is offered |
| req_ready | output | 1 | The block can take a request |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Beats minus one |
| req_size | input | SIZE_W | log2 of bytes per beat |
| req_kind | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| req_err | output | 1 | One-cycle pulse for a refused request |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | The consumer takes the beat address |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_last | output | 1 | Current beat is the final one |

## Verification
Incrementing bursts are run from unaligned start addresses and from addresses just below the top of the address space. These show whether the first-beat alignment and the modular rollover are right. Wrapping bursts are run from starts in the middle of the window, at its base and at its top, for every legal length. This separates a correct fold-back point from one that is off by a beat. Refused requests (bad lengths, misaligned starts, the reserved code) are placed between legal ones to show that the error leaves no trace in the next burst. A randomly gated beat_ready exposes any beat that changes or is lost under back-pressure.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;

endpackage

// File: rtl/burst_legal_chk.sv
module burst_legal_chk
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  burst_kind_e       kind,
  output logic              legal
);

  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] low_mask;
  logic              aligned;
  logic              wrap_len_ok;

  // Bits below the beat size must be zero for a wrapping start.
  assign low_mask = ~(ALL_ONES << size);
  assign aligned  = (start_addr & low_mask) == '0;

  always_comb begin
    case (len)
      LEN_W'(1), LEN_W'(3), LEN_W'(7), LEN_W'(15): wrap_len_ok = 1'b1;
      default:                                     wrap_len_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (kind)
      BK_FIXED: legal = 1'b1;
      BK_INCR:  legal = 1'b1;
      BK_WRAP:  legal = wrap_len_ok && aligned;
      default:  legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/burst_wrap_bounds.sv
module burst_wrap_bounds #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] win_lo,
  output logic [ADDR_W-1:0] win_hi
);

  localparam int PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] beats;
  logic [ADDR_W-1:0] total;

  // Total bytes of the burst. Only meaningful for legal wrap lengths,
  // where it is a power of two.
  assign beats  = {{PAD_W{1'b0}}, len} + ADDR_W'(1);
  assign total  = beats << size;
  assign win_lo = start_addr & ~(total - ADDR_W'(1));
  assign win_hi = win_lo + total;

endmodule

// File: rtl/burst_step.sv
module burst_step
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [SIZE_W-1:0] size,
  input  burst_kind_e       kind,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  output logic [ADDR_W-1:0] nxt_addr
);

  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] step_bytes;
  logic [ADDR_W-1:0] aligned_cur;
  logic [ADDR_W-1:0] bumped;

  assign step_bytes  = ONE << size;
  assign aligned_cur = cur_addr & (ALL_ONES << size);
  assign bumped      = aligned_cur + step_bytes;

  always_comb begin
    case (kind)
      BK_FIXED: nxt_addr = cur_addr;
      BK_WRAP:  nxt_addr = (bumped == win_hi) ? win_lo : bumped;
      default:  nxt_addr = bumped;
    endcase
  end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [SIZE_W-1:0] req_size,
  input  burst_kind_e       req_kind,
  input  logic              req_legal,
  input  logic [ADDR_W-1:0] req_win_lo,
  input  logic [ADDR_W-1:0] req_win_hi,
  output logic              req_err,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last,
  input  logic [ADDR_W-1:0] step_addr,
  output burst_kind_e       cur_kind,
  output logic [SIZE_W-1:0] cur_size,
  output logic [ADDR_W-1:0] cur_lo,
  output logic [ADDR_W-1:0] cur_hi
);

  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  logic [LEN_W-1:0] remain;
  logic             take_req;
  logic             take_beat;

  assign take_req  = req_valid && req_ready;
  assign take_beat = beat_valid && beat_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready  <= 1'b1;
      req_err    <= 1'b0;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      beat_addr  <= '0;
      remain     <= '0;
      cur_kind   <= BK_FIXED;
      cur_size   <= '0;
      cur_lo     <= '0;
      cur_hi     <= '0;
    end else begin
      req_err <= 1'b0;
      if (take_req) begin
        if (req_legal) begin
          req_ready  <= 1'b0;
          beat_valid <= 1'b1;
          beat_addr  <= req_addr;
          beat_last  <= (req_len == '0);
          remain     <= req_len;
          cur_kind   <= req_kind;
          cur_size   <= req_size;
          cur_lo     <= req_win_lo;
          cur_hi     <= req_win_hi;
        end else begin
          req_err <= 1'b1;
        end
      end else if (take_beat) begin
        if (beat_last) begin
          beat_valid <= 1'b0;
          beat_last  <= 1'b0;
          req_ready  <= 1'b1;
        end else begin
          beat_addr <= step_addr;
          remain    <= remain - LEN_W'(1);
          beat_last <= (remain == LEN_W'(1));
        end
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (req_ready && !beat_valid && !req_err && !beat_last)) else $error("reset idle"); // R1

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> !req_ready) else $error("request taken while busy"); // R10

  AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (take_beat && beat_last) |=> (!beat_valid && req_ready)) else $error("burst did not end"); // R10

  AST_LAST_ONLY_FINAL: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_last) |-> (remain == '0)) else $error("last flag early"); // R3

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_last)))
    else $error("beat changed under stall"); // R9

  AST_FIXED_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (take_beat && !beat_last && cur_kind == BK_FIXED) |=> (beat_addr == $past(beat_addr)))
    else $error("fixed address moved"); // R4

  AST_INCR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (take_beat && !beat_last && cur_kind == BK_INCR) |=> ((beat_addr & ~(ALL_ONES << cur_size)) == '0))
    else $error("incrementing beat unaligned"); // R5

  AST_WRAP_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && cur_kind == BK_WRAP) |-> ((beat_addr - cur_lo) < (cur_hi - cur_lo)))
    else $error("wrap address outside window"); // R6

  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!beat_valid && req_ready)) else $error("refused request emitted beats"); // R7

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [1:0]        req_kind,
  output logic              req_err,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last
);

  burst_kind_e       kind_in;
  logic              legal;
  logic [ADDR_W-1:0] req_lo;
  logic [ADDR_W-1:0] req_hi;
  logic [ADDR_W-1:0] nxt_addr;
  burst_kind_e       cur_kind;
  logic [SIZE_W-1:0] cur_size;
  logic [ADDR_W-1:0] cur_lo;
  logic [ADDR_W-1:0] cur_hi;

  assign kind_in = burst_kind_e'(req_kind);

  burst_legal_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_legal (
    .start_addr (req_addr),
    .len        (req_len),
    .size       (req_size),
    .kind       (kind_in),
    .legal      (legal)
  );

  burst_wrap_bounds #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_bounds (
    .start_addr (req_addr),
    .len        (req_len),
    .size       (req_size),
    .win_lo     (req_lo),
    .win_hi     (req_hi)
  );

  burst_step #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_step (
    .cur_addr (beat_addr),
    .size     (cur_size),
    .kind     (cur_kind),
    .win_lo   (cur_lo),
    .win_hi   (cur_hi),
    .nxt_addr (nxt_addr)
  );

  burst_seq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_size   (req_size),
    .req_kind   (kind_in),
    .req_legal  (legal),
    .req_win_lo (req_lo),
    .req_win_hi (req_hi),
    .req_err    (req_err),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_last  (beat_last),
    .step_addr  (nxt_addr),
    .cur_kind   (cur_kind),
    .cur_size   (cur_size),
    .cur_lo     (cur_lo),
    .cur_hi     (cur_hi)
  );

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

  localparam int AW = 32;
  localparam int LW = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [SW-1:0] req_size = '0;
  logic [1:0]    req_kind = 2'b00;
  logic          req_err;
  logic          beat_valid;
  logic          beat_ready = 1'b0;
  logic [AW-1:0] beat_addr;
  logic          beat_last;

  int n_checks = 0;
  int n_fails  = 0;
  int ready_pct = 60;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .SIZE_W(SW)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_kind(req_kind),
    .req_err(req_err),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .beat_last(beat_last)
  );

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected next address from the requirement text (R4, R5, R6).
  function automatic logic [AW-1:0] model_next(input logic [AW-1:0] cur, input logic [1:0] kind,
      input logic [SW-1:0] size, input logic [AW-1:0] lo, input logic [AW-1:0] tot);
    logic [AW-1:0] b;
    b = ((cur >> size) << size) + (AW'(1) << size);
    if (kind == 2'b00) return cur;
    if (kind == 2'b10 && b == lo + tot) return lo;
    return b;
  endfunction

  function automatic bit model_legal(input logic [AW-1:0] a, input logic [LW-1:0] len,
                                     input logic [SW-1:0] size, input logic [1:0] kind);
    if (kind == 2'b11) return 1'b0;
    if (kind != 2'b10) return 1'b1;
    if (!(len == 1 || len == 3 || len == 7 || len == 15)) return 1'b0;
    return (a & ((AW'(1) << size) - 1)) == '0;
  endfunction

  task automatic run_burst(input logic [AW-1:0] a, input logic [LW-1:0] len,
                           input logic [SW-1:0] size, input logic [1:0] kind);
    logic [AW-1:0] exp_a, tot, lo;
    int beats_seen;
    bit done;
    @(negedge clk);
    check(req_ready == 1'b1, "R10 idle before request", AW'(req_ready), AW'(1));
    req_valid = 1'b1; req_addr = a; req_len = len; req_size = size; req_kind = kind;
    beat_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (!model_legal(a, len, size, kind)) begin
      check(req_err == 1'b1, kind == 2'b11 ? "R8 reserved refused" : "R7 wrap refused",
            AW'(req_err), AW'(1));
      check(beat_valid == 1'b0 && req_ready == 1'b1, "R7 no beats after refusal",
            {beat_valid, req_ready}, 2'b01);
      @(negedge clk);
      check(req_err == 1'b0 && beat_valid == 1'b0, "R7 error is one pulse",
            {req_err, beat_valid}, 2'b00);
      return;
    end
    tot = (AW'(len) + 1) << size;
    lo = a & ~(tot - 1);
    exp_a = a;
    beats_seen = 0;
    done = 1'b0;
    while (!done) begin
      check(beat_valid == 1'b1, "R2 beat presented", AW'(beat_valid), AW'(1));
      check(beat_addr == exp_a,
            kind == 2'b00 ? "R4 fixed address" : (kind == 2'b01 ? "R5 incr address" : "R6 wrap address"),
            beat_addr, exp_a);
      check(beat_last == (beats_seen == int'(len)), "R3 last flag", AW'(beat_last),
            AW'(beats_seen == int'(len)));
      check(req_ready == 1'b0, "R10 busy blocks requests", AW'(req_ready), AW'(0));
      beat_ready = ($urandom_range(99) < ready_pct);
      if (beat_ready) begin
        beats_seen++;
        if (beats_seen == int'(len) + 1) done = 1'b1;
        exp_a = model_next(exp_a, kind, size, lo, tot);
      end else begin
        exp_a = exp_a; // R9: stalled beat must repeat
      end
      @(negedge clk);
      if (beats_seen > 300) done = 1'b1;
    end
    beat_ready = 1'b0;
    check(beats_seen == int'(len) + 1, "R3 beat count", AW'(beats_seen), AW'(len) + 1);
    check(beat_valid == 1'b0 && req_ready == 1'b1, "R10 idle after final beat",
          {beat_valid, req_ready}, 2'b01);
  endtask

  initial begin
    #1500000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    check(beat_valid == 1'b0 && req_ready == 1'b1 && req_err == 1'b0 && beat_last == 1'b0,
          "R1 state in reset", {beat_valid, req_ready, req_err, beat_last}, 4'b0100);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(beat_valid == 1'b0 && req_ready == 1'b1 && req_err == 1'b0,
          "R1 state after reset", {beat_valid, req_ready, req_err}, 3'b010);

    // Directed corner cases
    run_burst(32'h0000_0034, 8'd3, 3'd2, 2'b10);   // R6 mid-window wrap
    run_burst(32'h0000_0030, 8'd3, 3'd2, 2'b10);   // R6 wrap starting at base
    run_burst(32'h0000_003C, 8'd15, 3'd0, 2'b10);  // R6 wrap from near top, 16 beats
    run_burst(32'h0000_1003, 8'd2, 3'd2, 2'b01);   // R5 unaligned start
    run_burst(32'hFFFF_FFFC, 8'd2, 3'd2, 2'b01);   // R5 rollover at top
    run_burst(32'h0000_5555, 8'd5, 3'd3, 2'b00);   // R4 fixed
    run_burst(32'h0000_0100, 8'd0, 3'd1, 2'b01);   // R3 single beat
    run_burst(32'h0000_0000, 8'd255, 3'd0, 2'b01); // R3 longest burst
    run_burst(32'h0000_0040, 8'd2, 3'd2, 2'b10);   // R7 bad wrap length
    run_burst(32'h0000_0040, 8'd31, 3'd0, 2'b10);  // R7 length too long
    run_burst(32'h0000_0042, 8'd3, 3'd2, 2'b10);   // R7 misaligned start
    run_burst(32'h0000_0040, 8'd3, 3'd2, 2'b11);   // R8 reserved code
    ready_pct = 25;
    run_burst(32'h0000_0078, 8'd7, 3'd3, 2'b10);   // R9 heavy stalling in a wrap
    ready_pct = 100;
    run_burst(32'h0000_0200, 8'd4, 3'd2, 2'b01);   // R10 back-to-back beats

    // Constrained random mix
    for (int i = 0; i < 200; i++) begin
      logic [1:0] k;
      logic [SW-1:0] s;
      logic [LW-1:0] l;
      logic [AW-1:0] a;
      ready_pct = 30 + $urandom_range(70);
      k = 2'($urandom_range(3));
      s = SW'($urandom_range(7));
      a = $urandom;
      l = LW'($urandom_range(20));
      if (k == 2'b10 && $urandom_range(3) != 0) begin
        l = LW'((2 << $urandom_range(3)) - 1);
        a = (a >> s) << s;
      end
      run_burst(a, l, s, k);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule